// File: doc/BRIEF.md
# Pseudo-random nonuniform sampling pulse generator

This block turns a fast reference clock into a train of sampling pulses whose spacing changes from pulse to pulse under the control of a pseudo-random sequence. Each interval is measured by counting reference clock cycles. The cycle count comes from a 3-bit code drawn from a linear feedback shift register, with a fixed offset of nine added to it. A second random bit adds half a clock period to the interval. The fine half-period shift is made by an external delay element. The block drives that element through a one-bit select output, which carries the running half-cycle phase of the current pulse. A whole-cycle carry is folded back into the counter, so every sampling instant stays on a grid of half clock periods.

Each pulse is stretched to a fixed high time so that a downstream converter can latch it. The select bit and the current divide code change only at the rising edge of a pulse, so the external delay path never sees a change while a pulse is high. Software can load a seed into the random source. The enable input starts the train and stops it cleanly.

Top module: `nusamp_gen`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the cycle after it falls, `pulse_o`, `dly_sel_o` and `div_code_o` are all zero. The random state resets to 16'h0001.
- R2: The random source is a 16-bit right-shifting Galois LFSR with tap mask 16'hB400 (polynomial x^16+x^14+x^13+x^11+1). It advances exactly once per pulse, at the pulse's rising edge. Bits [2:0] of the new state appear on `div_code_o`, and bit 3 of the new state is that interval's half-period bit b.
- R3: The integer clock count from one rising edge of `pulse_o` to the next is `div_code_o + 9`, plus one more cycle when `dly_sel_o` of the earlier pulse and its bit b are both 1.
- R4: Take each pulse instant as twice its rising-edge cycle plus `dly_sel_o`, counted in half clock periods. The spacing from a pulse to the next is then 2*(code+9)+b, which gives 18 to 33 half periods (9.0 to 16.5 clock periods).
- R5: `dly_sel_o` is 0 on the first pulse after enable. On each later pulse it equals the previous pulse's `dly_sel_o` XOR the previous pulse's bit b.
- R6: `pulse_o` stays high for exactly 3 reference cycles per pulse.
- R7: `div_code_o` and `dly_sel_o` change only in the cycle where `pulse_o` rises, and hold their values until the next rise.
- R8: A high `seed_load` writes `seed_val` into the LFSR on the next clock. A zero `seed_val` is replaced by 16'h0001. If a pulse starts in the same cycle, its draw is taken from the old state before the seed is written.
- R9: Once `en` is low, a pulse already high completes its 3 cycles. After that `pulse_o` stays low until `en` returns. Re-enabling starts a new pulse with a fresh LFSR draw, and its `dly_sel_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Runs the pulse train while high |
| seed_load | input | 1 | Strobe that loads `seed_val` into the LFSR |
| seed_val | input | 16 | Seed value; zero is mapped to 16'h0001 |
| pulse_o | output | 1 | Stretched sampling pulse |
| dly_sel_o | output | 1 | Half-period fine delay select for the external delay element |
| div_code_o | output | 3 | Divide code of the current interval (ratio minus 9) |

## Verification
The bench builds the block with its default parameters: a 16-bit LFSR, a 3-bit code, a base ratio of 9 and a 3-cycle high time. With these values the intervals run from the shortest (code 0 with no half step) to the longest (code 7 plus a half step). Runs of about sixty pulses from several seeds reach both the phase-carry case, where an extra whole cycle is added, and the non-carry case. The bench timestamps every rising edge in half periods and compares each spacing with a reference LFSR model, so any departure from the half-cycle grid is reported. A zero seed, an enable drop in the middle of a pulse, and the restart that follows are each exercised with the same defaults.

// File: rtl/nusamp_gen.sv
module nusamp_gen #(
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAP_MASK = 16'hB400,
  parameter logic [LFSR_W-1:0] RST_SEED = 16'h0001,
  parameter int CODE_W = 3,
  parameter int RATIO_MIN = 9,
  parameter int HIGH_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              seed_load,
  input  logic [LFSR_W-1:0] seed_val,
  output logic              pulse_o,
  output logic              dly_sel_o,
  output logic [CODE_W-1:0] div_code_o
);
  localparam int RATIO_MAX = RATIO_MIN + (1 << CODE_W) - 1;
  localparam int PH_W = $clog2(RATIO_MAX + 2);

  logic [LFSR_W-1:0] lfsr, lfsr_nx;
  logic [PH_W-1:0]   ph, ph_last;
  logic              active, half_q, start;

  assign lfsr_nx = {1'b0, lfsr[LFSR_W-1:1]} ^ (lfsr[0] ? TAP_MASK : '0);
  assign ph_last = PH_W'(RATIO_MIN - 1) + PH_W'(div_code_o) + PH_W'(dly_sel_o & half_q);
  assign start   = en && (!active || ph == ph_last);
  assign pulse_o = active && (ph < PH_W'(HIGH_CYC));

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr       <= RST_SEED;
      active     <= 1'b0;
      ph         <= '0;
      half_q     <= 1'b0;
      dly_sel_o  <= 1'b0;
      div_code_o <= '0;
    end else begin
      if (seed_load)
        lfsr <= (seed_val == '0) ? LFSR_W'(1) : seed_val;
      else if (start)
        lfsr <= lfsr_nx;
      if (start) begin
        div_code_o <= lfsr_nx[CODE_W-1:0];
        half_q     <= lfsr_nx[CODE_W];
        dly_sel_o  <= active ? (dly_sel_o ^ half_q) : 1'b0;
        active     <= 1'b1;
        ph         <= '0;
      end else if (active) begin
        if (!en && ph >= PH_W'(HIGH_CYC - 1))
          active <= 1'b0;
        else
          ph <= ph + 1'b1;
      end
    end
  end

  assert_width_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse_o) |-> ($past(pulse_o, 2) && $past(pulse_o, 3)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !$rose(pulse_o) |-> ($stable(div_code_o) && $stable(dly_sel_o)));

  assert_lfsr_live_R2: assert property (@(posedge clk) disable iff (rst)
    lfsr != '0);

  assert_seed_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(seed_load) && !$past(rst)) |->
      (lfsr == (($past(seed_val) == '0) ? LFSR_W'(1) : $past(seed_val))));

  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(en) && !$past(pulse_o)) |-> !pulse_o);
endmodule

// File: tb/test_nusamp_gen.sv
module test_nusamp_gen;
  logic clk = 0, rst = 1, en = 0, seed_load = 0;
  logic [15:0] seed_val = '0;
  logic pulse_o, dly_sel_o;
  logic [2:0] div_code_o;
  int checks = 0, errors = 0, cyc = 0;
  bit cur_p = 0, done = 0;
  logic [15:0] m;

  nusamp_gen i_nusamp_gen (.clk(clk), .rst(rst), .en(en), .seed_load(seed_load),
    .seed_val(seed_val), .pulse_o(pulse_o), .dly_sel_o(dly_sel_o), .div_code_o(div_code_o));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] ref_next(input logic [15:0] s);
    logic [15:0] r;
    r = s >> 1;
    if (s[0]) r = r ^ 16'hB400;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cur_p = pulse_o;
  endtask

  task automatic wait_rise(input bit hold, input int hc, input int hd, output bit ok);
    bit prev;
    ok = 0;
    for (int i = 0; i < 100; i++) begin
      prev = cur_p;
      step();
      if (cur_p && !prev) begin ok = 1; return; end
      if (hold && (div_code_o != 3'(hc) || dly_sel_o != hd[0]))
        chk(0, "R7", "code/dly changed between pulses", {div_code_o, dly_sel_o}, {3'(hc), hd[0]});
    end
    chk(0, "R3", "no pulse rise within timeout", 0, 1);
  endtask

  task automatic chk_width(input string req);
    bit w;
    w = cur_p;
    step(); w = w & cur_p;
    step(); w = w & cur_p;
    step(); w = w & !cur_p;
    chk(w, req, "pulse high exactly 3 cycles", w, 1);
  endtask

  task automatic load_seed(input logic [15:0] s);
    seed_load = 1; seed_val = s;
    step();
    seed_load = 0;
    m = (s == 0) ? 16'h0001 : s;
  endtask

  task automatic t_reset();
    rst = 1; en = 0;
    repeat (3) step();
    chk(!pulse_o && !dly_sel_o && div_code_o == 0, "R1", "outputs in reset", {pulse_o, dly_sel_o, div_code_o}, 0);
    rst = 0;
    step();
    chk(!pulse_o && !dly_sel_o && div_code_o == 0, "R1", "outputs after reset", {pulse_o, dly_sel_o, div_code_o}, 0);
    repeat (20) step();
    chk(!pulse_o, "R9", "idle while disabled", pulse_o, 0);
  endtask

  task automatic t_run(input logic [15:0] seed, input int n);
    int pc = 0, pd = 0, pb = 0, pt = 0, t, sp, carries = 0;
    bit ok;
    load_seed(seed);
    en = 1;
    for (int k = 0; k < n; k++) begin
      wait_rise(k > 0, pc, pd, ok);
      if (!ok) return;
      m = ref_next(m);
      chk(div_code_o == m[2:0], "R2", "divide code", div_code_o, m[2:0]);
      chk(dly_sel_o == ((k == 0) ? 1'b0 : 1'(pd ^ pb)), "R5", "delay select", dly_sel_o, (k == 0) ? 0 : (pd ^ pb));
      t = 2 * cyc + int'(dly_sel_o);
      if (k > 0) begin
        sp = t - pt;
        chk(sp == 2 * (pc + 9) + pb, "R4", "half-period spacing", sp, 2 * (pc + 9) + pb);
        chk(sp >= 18 && sp <= 33, "R3", "spacing range", sp, 18);
        if (pd == 1 && pb == 1) carries++;
      end
      pc = m[2:0]; pb = int'(m[3]); pd = int'(dly_sel_o); pt = t;
      if (k == n - 1) en = 0;
      chk_width("R6");
    end
    repeat (25) step();
    chk(!pulse_o, "R9", "idle after stop", pulse_o, 0);
    $display("run seed=%h carries=%0d", seed, carries);
  endtask

  task automatic t_abort();
    bit ok;
    load_seed(16'h5A3C);
    en = 1;
    wait_rise(0, 0, 0, ok);
    if (!ok) return;
    m = ref_next(m);
    chk(div_code_o == m[2:0], "R2", "code before abort", div_code_o, m[2:0]);
    en = 0;
    chk_width("R9");
    for (int i = 0; i < 30; i++) begin
      step();
      if (cur_p) chk(0, "R9", "pulse while disabled", 1, 0);
    end
    checks++;
    en = 1;
    wait_rise(0, 0, 0, ok);
    if (!ok) return;
    m = ref_next(m);
    chk(div_code_o == m[2:0], "R9", "fresh draw on restart", div_code_o, m[2:0]);
    chk(dly_sel_o == 0, "R9", "phase zero on restart", dly_sel_o, 0);
    en = 0;
    chk_width("R6");
    repeat (5) step();
  endtask

  initial begin
    t_reset();
    t_run(16'hACE1, 60);
    t_run(16'h0000, 30);
    t_run(16'h8001, 60);
    t_abort();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule